// File: doc/BRIEF.md
# Ten-bit serializer with loopback

This block is the transmit side of a gigabit serial link. It takes one pre-encoded 10-bit code group per byte period and sends it out one bit at a time, bit 0 first. The code groups pass through unchanged; the block does no encoding of its own. Everything runs in one fast clock domain. The serial bit clock is a synchronous enable, `bit_en_i`, which is high for one clock per bit slot. A byte period is ten enabled slots.

An internal slot counter decides when the parallel word is captured. The block marks that capture edge by raising `byte_tick_o`, which is its model of the byte clock. The host must hold `data_i` valid across that edge. Each captured word reaches the shift register at the slot boundary after bit 9 of the word ahead of it, so consecutive words leave with no gap between them. The first bit of a word goes out exactly four bit slots after the word is captured.

The wrap input chooses where the stream goes. When wrap is low, the stream drives the differential line pair. When wrap is high, the stream goes to the loopback output and the line pair is held at a static one.

Top module: `tx_serializer`

## Requirements
- R1: `byte_tick_o` is high exactly in the clock cycles where `bit_en_i` is high and the internal slot count is 5. The slot count starts at 0 after reset, advances by one on each enabled slot and returns to 0 after 9. `data_i` is captured on that clock edge.
- R2: A captured word is sent over ten consecutive enabled slots, bit 0 first and bit 9 last. The next captured word follows immediately, with no idle slot between words.
- R3: The first bit of a word appears on the serial stream after the fourth enabled clock edge that follows its capture edge, and not before.
- R4: While `wrap_i` is 1, `loop_o` carries the serial stream, `line_p_o` is 1 and `line_n_o` is 0, whatever the data.
- R5: While `wrap_i` is 0, `line_p_o` carries the serial stream, `line_n_o` is its inverse, and `loop_o` is held at 1.
- R6: After reset the serial stream is 1 until the first captured word reaches the load point at the end of slot 9.
- R7: In a clock cycle with `bit_en_i` low, the serial stream does not change.
- R8: Any 10-bit value, including all zeros, all ones and the comma patterns 0x17C and 0x283, is sent bit for bit without change.
- R9: Asserting `rst_ni` (active low, asynchronous) in the middle of a word at once returns the stream to 1 and the slot count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-slot enable, high for one clock per serial bit |
| wrap_i | input | 1 | 1 sends the stream to loopback and holds the line at one |
| data_i | input | 10 | Encoded code group, bit 0 sent first |
| byte_tick_o | output | 1 | High in the cycle whose clock edge captures `data_i` |
| line_p_o | output | 1 | Line output, true side |
| line_n_o | output | 1 | Line output, complement side |
| loop_o | output | 1 | Loopback serial output |

## Verification
The hardest case to provoke from the ports is the first word after reset. Idle ones and data ones look the same on the pins, and the capture phase is fixed inside the block. To prove the four-slot latency, the bench waits for the first capture strobe, captures a word whose bit 0 is zero, and counts enabled edges until the line drops. The bench also varies the enable cadence, stalls the enable for a long stretch, toggles wrap in the middle of words, and pulls reset in the middle of a word. It checks every cycle against its own slot-level model of the stream.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;
  typedef enum logic {
    ROUTE_LINE = 1'b0,
    ROUTE_WRAP = 1'b1
  } route_e;
endpackage

// File: rtl/tx_slot_ctr.sv
module tx_slot_ctr #(
  parameter int unsigned SYM_W    = 10,
  parameter int unsigned CAP_SLOT = 5,
  localparam int unsigned CNT_W   = $clog2(SYM_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  output logic             cap_o,
  output logic             load_o,
  output logic [CNT_W-1:0] slot_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(CAP_SLOT);

  logic [CNT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       slot_q <= '0;
    else if (bit_en_i) slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
  end

  assign cap_o  = bit_en_i && (slot_q == CAP);
  assign load_o = bit_en_i && (slot_q == LAST);
  assign slot_o = slot_q;
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int unsigned SYM_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [SYM_W-1:0] data_i,
  output logic [SYM_W-1:0] hold_o
);
  // reset to ones so an early load emits idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_o <= '1;
    else if (cap_i) hold_o <= data_i;
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int unsigned SYM_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             load_i,
  input  logic [SYM_W-1:0] par_i,
  output logic             ser_o
);
  logic [SYM_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '1;
    else if (bit_en_i) sh_q <= load_i ? par_i : {1'b1, sh_q[SYM_W-1:1]};
  end

  assign ser_o = sh_q[0];
endmodule

// File: rtl/tx_route.sv
module tx_route
  import tx_ser_pkg::*;
(
  input  route_e route_i,
  input  logic   ser_i,
  output logic   line_p_o,
  output logic   line_n_o,
  output logic   loop_o
);
  always_comb begin
    unique case (route_i)
      ROUTE_WRAP: begin
        line_p_o = 1'b1;
        loop_o   = ser_i;
      end
      default: begin
        line_p_o = ser_i;
        loop_o   = 1'b1;
      end
    endcase
    line_n_o = ~line_p_o;
  end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import tx_ser_pkg::*;
#(
  parameter int unsigned SYM_W     = 10,
  parameter int unsigned LAT_SLOTS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             wrap_i,
  input  logic [SYM_W-1:0] data_i,
  output logic             byte_tick_o,
  output logic             line_p_o,
  output logic             line_n_o,
  output logic             loop_o
);
  localparam int unsigned CNT_W    = $clog2(SYM_W);
  localparam int unsigned CAP_SLOT = SYM_W - 1 - LAT_SLOTS;

  generate
    if (LAT_SLOTS >= SYM_W) begin : g_bad_lat
      $error("LAT_SLOTS must be below SYM_W");
    end
  endgenerate

  logic             cap_w, load_w, ser_w;
  logic [CNT_W-1:0] slot_w;
  logic [SYM_W-1:0] hold_w;

  tx_slot_ctr #(.SYM_W(SYM_W), .CAP_SLOT(CAP_SLOT)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i),
    .cap_o(cap_w), .load_o(load_w), .slot_o(slot_w)
  );

  tx_hold_reg #(.SYM_W(SYM_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap_w),
    .data_i(data_i), .hold_o(hold_w)
  );

  tx_shifter #(.SYM_W(SYM_W)) u_sh (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i),
    .load_i(load_w), .par_i(hold_w), .ser_o(ser_w)
  );

  tx_route u_route (
    .route_i(route_e'(wrap_i)), .ser_i(ser_w),
    .line_p_o(line_p_o), .line_n_o(line_n_o), .loop_o(loop_o)
  );

  assign byte_tick_o = cap_w;
endmodule

// File: rtl/tx_serializer_chk.sv
module tx_serializer_chk #(
  parameter int unsigned SYM_W = 10,
  localparam int unsigned CNT_W = $clog2(SYM_W)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_en_i,
  input logic             wrap_i,
  input logic             byte_tick_o,
  input logic             line_p_o,
  input logic             line_n_o,
  input logic             loop_o,
  input logic             ser_w,
  input logic [CNT_W-1:0] slot_w
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

  logic cap_seen, load_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_seen  <= 1'b0;
      load_seen <= 1'b0;
    end else begin
      if (byte_tick_o) cap_seen <= 1'b1;
      if (bit_en_i && slot_w == LAST && cap_seen) load_seen <= 1'b1;
    end
  end

  assert_tick_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_tick_o |=> !byte_tick_o);

  assert_wrap_line_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |-> (line_p_o && !line_n_o && loop_o == ser_w));

  assert_line_path_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |-> (loop_o && line_p_o == ser_w && line_n_o == !ser_w));

  assert_idle_before_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_seen |-> ser_w);

  assert_stall_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(ser_w));
endmodule

bind tx_serializer tx_serializer_chk #(.SYM_W(SYM_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .wrap_i(wrap_i),
  .byte_tick_o(byte_tick_o), .line_p_o(line_p_o), .line_n_o(line_n_o),
  .loop_o(loop_o), .ser_w(ser_w), .slot_w(slot_w)
);

// File: tb/tx_serializer_tb.sv
module tx_serializer_tb;
  localparam int SYM_W = 10;
  localparam int LAT   = 4;
  localparam int CAP   = SYM_W - 1 - LAT;
  localparam int NVEC  = 16;
  // {wrap, word}
  localparam logic [SYM_W:0] VEC [NVEC] = '{
    11'h17C, 11'h283, 11'h000, 11'h3FF, 11'h555, 11'h2AA, 11'h001, 11'h200,
    11'h4F0, 11'h60F, 11'h17C, 11'h683, 11'h133, 11'h0CC, 11'h7FF, 11'h000
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, bit_en_i = 1'b0, wrap_i = 1'b0;
  logic [SYM_W-1:0] data_i = '0;
  logic byte_tick_o, line_p_o, line_n_o, loop_o;

  int n_run = 0, n_fail = 0;
  int div = 1, gcnt = 0;
  bit chk_on = 1'b0, done = 1'b0;

  // bench reference state
  int bslot = 0, bidx = 0;
  bit pend_v = 0, cur_v = 0, exp_ser = 1;
  logic [SYM_W-1:0] pend, cur;

  tx_serializer #(.SYM_W(SYM_W), .LAT_SLOTS(LAT)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .wrap_i(wrap_i),
    .data_i(data_i), .byte_tick_o(byte_tick_o), .line_p_o(line_p_o),
    .line_n_o(line_n_o), .loop_o(loop_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    #1;
    gcnt++;
    bit_en_i = (div != 0) && (gcnt % (div == 0 ? 1 : div) == 0);
  end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bslot = 0; bidx = 0; pend_v = 0; cur_v = 0; exp_ser = 1;
    end else if (bit_en_i) begin
      if (bslot == SYM_W - 1 && pend_v) begin
        cur = pend; cur_v = 1; bidx = 0;
      end else if (cur_v) begin
        bidx++;
        if (bidx >= SYM_W) cur_v = 0;
      end
      if (bslot == CAP) begin
        pend = data_i; pend_v = 1;
      end
      bslot = (bslot == SYM_W - 1) ? 0 : bslot + 1;
      exp_ser = cur_v ? cur[bidx] : 1'b1;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // continuous comparison against the reference stream (R2, R4, R5, R8, R1)
  always @(posedge clk_i) begin
    #3;
    if (chk_on && rst_ni) begin
      check("R1 byte_tick", byte_tick_o, bit_en_i && bslot == CAP);
      if (wrap_i) begin
        check("R4 line_p", line_p_o, 1'b1);
        check("R4 line_n", line_n_o, 1'b0);
        check("R4/R2 loop", loop_o, exp_ser);
      end else begin
        check("R5/R2 line_p", line_p_o, exp_ser);
        check("R5 line_n", line_n_o, ~exp_ser);
        check("R5 loop", loop_o, 1'b1);
      end
    end
  end

  task automatic wait_cap();
    do @(negedge clk_i); while (!(bit_en_i && bslot == CAP));
  endtask

  task automatic wait_en_edges(input int n);
    for (int k = 0; k < n; k++) begin
      do @(posedge clk_i); while (!bit_en_i);
    end
    #3;
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R6 reset state
    check("R6 reset line_p", line_p_o, 1'b1);
    check("R6 reset line_n", line_n_o, 1'b0);
    check("R6 reset loop", loop_o, 1'b1);
    rst_ni = 1'b1;
    chk_on = 1'b1;

    // R3 first-word latency: bit0 = 0 must show on the 4th enabled edge
    data_i = 10'h3FE;
    wait_cap();
    @(posedge clk_i); #3;
    check("R6 idle after capture", line_p_o, 1'b1);
    wait_en_edges(LAT - 1);
    check("R3 before latency", line_p_o, 1'b1);
    wait_en_edges(1);
    check("R3 first bit", line_p_o, 1'b0);

    // table walk (R2, R4, R5, R8)
    for (int i = 0; i < NVEC; i++) begin
      div = (i < NVEC / 2) ? 1 : 2;
      wait_cap();
      wrap_i = VEC[i][SYM_W];
      data_i = VEC[i][SYM_W-1:0];
    end
    wait_cap();
    wrap_i = 1'b0;
    data_i = 10'h0F3;

    // R7 stall: hold enable low, stream must not move
    wait_en_edges(3);
    div = 0;
    @(negedge clk_i);
    begin
      logic ref_p;
      ref_p = line_p_o;
      for (int k = 0; k < 25; k++) begin
        @(negedge clk_i);
        if (k % 5 == 0) check("R7 stall", line_p_o, ref_p);
      end
    end
    div = 3;

    // R4 wrap toggled mid-word
    wait_cap();
    data_i = 10'h2D4;
    wait_en_edges(6);
    @(negedge clk_i) wrap_i = 1'b1;
    wait_en_edges(2);
    @(negedge clk_i) wrap_i = 1'b0;
    wait_en_edges(3);

    // R9 asynchronous reset mid-word
    div = 1;
    wait_cap();
    data_i = 10'h000;
    wait_en_edges(LAT + 2);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R9 line_p", line_p_o, 1'b1);
    check("R9 line_n", line_n_o, 1'b0);
    check("R9 loop", loop_o, 1'b1);
    @(negedge clk_i) rst_ni = 1'b1;
    data_i = 10'h1AB;
    wait_cap();
    check("R9 slot restart", bslot, CAP);
    repeat (3 * SYM_W) @(negedge clk_i);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule